// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block chooses which ready instructions issue in a cycle. Five ready queues, one each for the integer, floating-point, branch, memory and miscellaneous classes, show their leading `WIN` entries to the block. Each entry has a valid bit, a squashed bit and a sequence number, and each queue is sorted with its oldest entry at index 0. The block makes up to `ISSUE_W` selection steps. Each step first discards squashed entries at the heads of the eligible queues. It then issues the eligible head with the smallest sequence number. The steps are unrolled in combinational logic, and each step sees the heads left by the steps before it.

The class caps limit the integer, floating-point, branch and memory classes. The miscellaneous class is limited only by the total width. All results are registered, so they appear one cycle after the heads are presented. The results are the issue slots, the issue size (which is also the count of window entries freed this cycle), the issued count for each class, and the pop count for each class. The queue owner uses the pop count to retire the entries that were consumed, whether they were issued or discarded.

Class codes fix the order of comparison: integer=0, floating-point=1, branch=2, memory=3, miscellaneous=4.

Top module: `iqsel_top`

## Requirements
- R1: While reset is held, every output is zero.
- R2: Issued slots are packed from slot 0 upward. Each step issues the eligible head with the numerically smallest sequence number, so the sequence numbers in the used slots strictly increase.
- R3: The issued counts per class never exceed the caps: CAP_INT for class 0, CAP_FP for class 1, CAP_BR for class 2 and CAP_MEM for class 3. A class that has reached its cap is not eligible for the rest of the cycle.
- R4: `iss_size_o` never exceeds ISSUE_W and always equals the sum of the per-class issued counts.
- R5: The miscellaneous class (code 4) has no cap of its own. It can fill all ISSUE_W slots.
- R6: A squashed entry at the head of an eligible queue is discarded. It takes no slot and adds nothing to its class count, but it does add to that class's pop count.
- R7: Squashed entries are discarded only at a step that still runs with the class eligible. They stay in place once the class has reached its cap or the total width has been filled.
- R8: Slots at index `iss_size_o` and above read zero, for both sequence number and class.
- R9: For each class, the pop count equals the issued count plus the number of discarded entries. It is therefore never below the issued count.
- R10: Results appear on the clock edge after the heads are presented. Counts start from zero in every cycle, so identical inputs on back-to-back cycles give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_vld_i | input | 5*WIN | Valid bit per class per window entry (contiguous from index 0) |
| hd_sq_i | input | 5*WIN | Squashed bit per class per window entry |
| hd_seq_i | input | 5*WIN*SEQ_W | Sequence number per class per window entry, ascending in each class |
| iss_size_o | output | CNT_W | Number of slots issued this cycle; also the freed-entry credit |
| iss_seq_o | output | ISSUE_W*SEQ_W | Sequence number of each issue slot |
| iss_cls_o | output | ISSUE_W*3 | Class code of each issue slot |
| cls_cnt_o | output | 5*CNT_W | Issued count per class |
| pop_cnt_o | output | 5*PTR_W | Entries consumed (issued or discarded) per class |

## Verification
Random windows with mixed depths, interleaved sequence numbers and about one squashed entry in four are checked against a sequential reference. That reference walks the discard, pick, count loop one instruction at a time, so it tests the unrolled steps against step-by-step behaviour.

Directed cases cover the remaining corners:
- Old integer entries that stop at the integer cap separate a global oldest-first pick from a per-class cap.
- A window of only miscellaneous entries shows that this class is bound by the total width alone.
- Leading squashed entries separate discarding from issuing.
- Squashed entries sitting behind a capped branch head, or behind the last slot filled, show that discarding stops when eligibility ends.
- Repeated identical inputs confirm that the counts restart every cycle.

// File: rtl/iqsel_pkg.sv
package iqsel_pkg;
    localparam int NCLS  = 5;
    localparam int CLS_W = 3;

    // Comparison order matters: lower code wins a tie on age.
    typedef enum logic [CLS_W-1:0] {
        CLS_INT  = 3'd0,
        CLS_FP   = 3'd1,
        CLS_BR   = 3'd2,
        CLS_MEM  = 3'd3,
        CLS_MISC = 3'd4
    } cls_e;
endpackage

// File: rtl/iqsel_skip.sv
// Advances one class's read pointer past leading squashed entries.
module iqsel_skip #(
    parameter int WIN   = 4,
    parameter int PTR_W = 3
) (
    input  logic             en_i,
    input  logic [WIN-1:0]   vld_i,
    input  logic [WIN-1:0]   sq_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [PTR_W-1:0] ptr_o
);
    logic [PTR_W-1:0] ptr_d;
    logic             stop_d;

    always_comb begin
        ptr_d  = ptr_i;
        stop_d = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            if (!stop_d && PTR_W'(i) >= ptr_i) begin
                if (vld_i[i] && sq_i[i]) begin
                    ptr_d = PTR_W'(i + 1);
                end else begin
                    stop_d = 1'b1;
                end
            end
        end
        ptr_o = en_i ? ptr_d : ptr_i;
    end
endmodule

// File: rtl/iqsel_stage.sv
// One selection step: discard squashed heads, then pick the oldest eligible head.
module iqsel_stage import iqsel_pkg::*; #(
    parameter int ISSUE_W = 4,
    parameter int WIN     = 4,
    parameter int SEQ_W   = 16,
    parameter int CAP_INT = 2,
    parameter int CAP_FP  = 2,
    parameter int CAP_BR  = 1,
    parameter int CAP_MEM = 2,
    parameter int CNT_W   = 3,
    parameter int PTR_W   = 3
) (
    input  logic                                act_i,
    input  logic [NCLS-1:0][WIN-1:0]            vld_i,
    input  logic [NCLS-1:0][WIN-1:0]            sq_i,
    input  logic [NCLS-1:0][WIN-1:0][SEQ_W-1:0] seq_i,
    input  logic [NCLS-1:0][PTR_W-1:0]          ptr_i,
    input  logic [NCLS-1:0][CNT_W-1:0]          cnt_i,
    output logic [NCLS-1:0][PTR_W-1:0]          ptr_o,
    output logic [NCLS-1:0][CNT_W-1:0]          cnt_o,
    output logic                                hit_o,
    output logic [SEQ_W-1:0]                    seq_o,
    output logic [CLS_W-1:0]                    cls_o
);
    localparam logic [NCLS-1:0][CNT_W-1:0] CAP = {
        CNT_W'(ISSUE_W), CNT_W'(CAP_MEM), CNT_W'(CAP_BR), CNT_W'(CAP_FP), CNT_W'(CAP_INT)
    };

    logic [NCLS-1:0]                   elig;
    logic [NCLS-1:0][PTR_W-1:0]        ptr_s;
    logic [NCLS-1:0]                   head_v;
    logic [NCLS-1:0][SEQ_W-1:0]        head_s;
    logic [SEQ_W-1:0]                  best;
    logic [CLS_W-1:0]                  sel;
    logic                              hit;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign elig[c] = act_i && (cnt_i[c] < CAP[c]);
        iqsel_skip #(.WIN(WIN), .PTR_W(PTR_W)) u_skip (
            .en_i  (elig[c]),
            .vld_i (vld_i[c]),
            .sq_i  (sq_i[c]),
            .ptr_i (ptr_i[c]),
            .ptr_o (ptr_s[c])
        );
    end

    always_comb begin
        for (int c = 0; c < NCLS; c++) begin
            head_v[c] = 1'b0;
            head_s[c] = '1;
            for (int i = 0; i < WIN; i++) begin
                if (elig[c] && ptr_s[c] == PTR_W'(i) && vld_i[c][i]) begin
                    head_v[c] = 1'b1;
                    head_s[c] = seq_i[c][i];
                end
            end
        end
        best = '1;
        sel  = '0;
        hit  = 1'b0;
        for (int c = 0; c < NCLS; c++) begin
            if (head_v[c] && (!hit || head_s[c] < best)) begin
                hit  = 1'b1;
                best = head_s[c];
                sel  = CLS_W'(c);
            end
        end
        for (int c = 0; c < NCLS; c++) begin
            if (hit && sel == CLS_W'(c)) begin
                ptr_o[c] = ptr_s[c] + PTR_W'(1);
                cnt_o[c] = cnt_i[c] + CNT_W'(1);
            end else begin
                ptr_o[c] = ptr_s[c];
                cnt_o[c] = cnt_i[c];
            end
        end
        hit_o = hit;
        seq_o = hit ? best : '0;
        cls_o = sel;
    end
endmodule

// File: rtl/iqsel_top.sv
module iqsel_top import iqsel_pkg::*; #(
    parameter int ISSUE_W = 4,
    parameter int WIN     = 4,
    parameter int SEQ_W   = 16,
    parameter int CAP_INT = 2,
    parameter int CAP_FP  = 2,
    parameter int CAP_BR  = 1,
    parameter int CAP_MEM = 2,
    localparam int CNT_W  = $clog2(ISSUE_W + 1),
    localparam int PTR_W  = $clog2(WIN + 1)
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic [NCLS-1:0][WIN-1:0]               hd_vld_i,
    input  logic [NCLS-1:0][WIN-1:0]               hd_sq_i,
    input  logic [NCLS-1:0][WIN-1:0][SEQ_W-1:0]    hd_seq_i,
    output logic [CNT_W-1:0]                       iss_size_o,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]          iss_seq_o,
    output logic [ISSUE_W-1:0][CLS_W-1:0]          iss_cls_o,
    output logic [NCLS-1:0][CNT_W-1:0]             cls_cnt_o,
    output logic [NCLS-1:0][PTR_W-1:0]             pop_cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0]              size;
        logic [ISSUE_W-1:0][SEQ_W-1:0] seq;
        logic [ISSUE_W-1:0][CLS_W-1:0] cls;
        logic [NCLS-1:0][CNT_W-1:0]    cnt;
        logic [NCLS-1:0][PTR_W-1:0]    pop;
    } out_t;

    out_t out_d, out_q;

    logic [NCLS-1:0][PTR_W-1:0] ptr_ch [ISSUE_W+1];
    logic [NCLS-1:0][CNT_W-1:0] cnt_ch [ISSUE_W+1];
    logic [ISSUE_W:0]           act_ch;
    logic [ISSUE_W-1:0]         hit;
    logic [ISSUE_W-1:0][SEQ_W-1:0] pick_seq;
    logic [ISSUE_W-1:0][CLS_W-1:0] pick_cls;

    assign ptr_ch[0] = '0;
    assign cnt_ch[0] = '0;
    assign act_ch[0] = 1'b1;

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_step
        iqsel_stage #(
            .ISSUE_W(ISSUE_W), .WIN(WIN), .SEQ_W(SEQ_W),
            .CAP_INT(CAP_INT), .CAP_FP(CAP_FP), .CAP_BR(CAP_BR), .CAP_MEM(CAP_MEM),
            .CNT_W(CNT_W), .PTR_W(PTR_W)
        ) u_stage (
            .act_i (act_ch[k]),
            .vld_i (hd_vld_i),
            .sq_i  (hd_sq_i),
            .seq_i (hd_seq_i),
            .ptr_i (ptr_ch[k]),
            .cnt_i (cnt_ch[k]),
            .ptr_o (ptr_ch[k+1]),
            .cnt_o (cnt_ch[k+1]),
            .hit_o (hit[k]),
            .seq_o (pick_seq[k]),
            .cls_o (pick_cls[k])
        );
        // A step that finds nothing ends the cycle's selection.
        assign act_ch[k+1] = hit[k];
    end

    always_comb begin
        out_d = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            out_d.size   = out_d.size + CNT_W'(hit[k]);
            out_d.seq[k] = hit[k] ? pick_seq[k] : '0;
            out_d.cls[k] = hit[k] ? pick_cls[k] : '0;
        end
        out_d.cnt = cnt_ch[ISSUE_W];
        out_d.pop = ptr_ch[ISSUE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign iss_size_o = out_q.size;
    assign iss_seq_o  = out_q.seq;
    assign iss_cls_o  = out_q.cls;
    assign cls_cnt_o  = out_q.cnt;
    assign pop_cnt_o  = out_q.pop;
endmodule

// File: rtl/iqsel_chk.sv
module iqsel_chk import iqsel_pkg::*; #(
    parameter int ISSUE_W = 4,
    parameter int SEQ_W   = 16,
    parameter int CAP_INT = 2,
    parameter int CAP_FP  = 2,
    parameter int CAP_BR  = 1,
    parameter int CAP_MEM = 2,
    parameter int CNT_W   = 3,
    parameter int PTR_W   = 3
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic [CNT_W-1:0]              iss_size_o,
    input logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq_o,
    input logic [ISSUE_W-1:0][CLS_W-1:0] iss_cls_o,
    input logic [NCLS-1:0][CNT_W-1:0]    cls_cnt_o,
    input logic [NCLS-1:0][PTR_W-1:0]    pop_cnt_o
);
    localparam logic [NCLS-2:0][CNT_W-1:0] CAPV = {
        CNT_W'(CAP_MEM), CNT_W'(CAP_BR), CNT_W'(CAP_FP), CNT_W'(CAP_INT)
    };

    logic [CNT_W+2:0] cnt_sum;
    always_comb begin
        cnt_sum = '0;
        for (int c = 0; c < NCLS; c++) begin
            cnt_sum = cnt_sum + {3'b000, cls_cnt_o[c]};
        end
    end

    // R4
    size_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss_size_o <= CNT_W'(ISSUE_W)) && (cnt_sum == {3'b000, iss_size_o}));

    for (genvar c = 0; c < NCLS - 1; c++) begin : g_cap
        // R3
        class_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cls_cnt_o[c] <= CAPV[c]);
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_pop
        // R9
        pop_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            {1'b0, pop_cnt_o[c]} >= (PTR_W+1)'(cls_cnt_o[c]));
    end

    for (genvar i = 0; i < ISSUE_W; i++) begin : g_slot
        // R8
        idle_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (CNT_W'(i) >= iss_size_o) |-> (iss_seq_o[i] == '0 && iss_cls_o[i] == '0));
        if (i < ISSUE_W - 1) begin : g_ord
            // R2
            age_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (CNT_W'(i + 1) < iss_size_o) |-> (iss_seq_o[i] < iss_seq_o[i+1]));
        end
    end
endmodule

bind iqsel_top iqsel_chk #(
    .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W),
    .CAP_INT(CAP_INT), .CAP_FP(CAP_FP), .CAP_BR(CAP_BR), .CAP_MEM(CAP_MEM),
    .CNT_W(CNT_W), .PTR_W(PTR_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iss_size_o (iss_size_o),
    .iss_seq_o  (iss_seq_o),
    .iss_cls_o  (iss_cls_o),
    .cls_cnt_o  (cls_cnt_o),
    .pop_cnt_o  (pop_cnt_o)
);

// File: tb/iqsel_top_bench.sv
module iqsel_top_bench;
    import iqsel_pkg::*;

    localparam int ISSUE_W = 4;
    localparam int WIN     = 4;
    localparam int SEQ_W   = 16;
    localparam int CNT_W   = $clog2(ISSUE_W + 1);
    localparam int PTR_W   = $clog2(WIN + 1);
    localparam int CAPS [NCLS] = '{2, 2, 1, 2, ISSUE_W};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCLS-1:0][WIN-1:0]            vld;
    logic [NCLS-1:0][WIN-1:0]            sq;
    logic [NCLS-1:0][WIN-1:0][SEQ_W-1:0] seqv;
    logic [CNT_W-1:0]                    iss_size;
    logic [ISSUE_W-1:0][SEQ_W-1:0]       iss_seq;
    logic [ISSUE_W-1:0][CLS_W-1:0]       iss_cls;
    logic [NCLS-1:0][CNT_W-1:0]          cls_cnt;
    logic [NCLS-1:0][PTR_W-1:0]          pop_cnt;

    int total = 0;
    int bad   = 0;
    int e_size;
    int e_seq [ISSUE_W];
    int e_cls [ISSUE_W];
    int e_cnt [NCLS];
    int e_pop [NCLS];

    always #10 clk = ~clk;

    iqsel_top u_iqsel_top (
        .clk_i(clk), .rst_ni(rst_n),
        .hd_vld_i(vld), .hd_sq_i(sq), .hd_seq_i(seqv),
        .iss_size_o(iss_size), .iss_seq_o(iss_seq), .iss_cls_o(iss_cls),
        .cls_cnt_o(cls_cnt), .pop_cnt_o(pop_cnt)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        vld = '0; sq = '0; seqv = '0;
    endtask

    task automatic put(int c, int i, int s, bit q);
        vld[c][i]  = 1'b1;
        sq[c][i]   = q;
        seqv[c][i] = SEQ_W'(s);
    endtask

    // Sequential reference: discard eligible squashed heads, then pick the oldest.
    task automatic model();
        int ptr [NCLS];
        int cnt [NCLS];
        int done;
        e_size = 0;
        done = 0;
        for (int c = 0; c < NCLS; c++) begin ptr[c] = 0; cnt[c] = 0; end
        for (int k = 0; k < ISSUE_W; k++) begin e_seq[k] = 0; e_cls[k] = 0; end
        while (e_size < ISSUE_W && done == 0) begin
            int best;
            int best_seq;
            for (int c = 0; c < NCLS; c++) begin
                if (cnt[c] < CAPS[c]) begin
                    while (ptr[c] < WIN && vld[c][ptr[c]] && sq[c][ptr[c]]) ptr[c]++;
                end
            end
            best = -1;
            best_seq = 0;
            for (int c = 0; c < NCLS; c++) begin
                if (cnt[c] < CAPS[c] && ptr[c] < WIN && vld[c][ptr[c]]) begin
                    if (best < 0 || int'(seqv[c][ptr[c]]) < best_seq) begin
                        best = c;
                        best_seq = int'(seqv[c][ptr[c]]);
                    end
                end
            end
            if (best < 0) begin
                done = 1;
            end else begin
                e_seq[e_size] = best_seq;
                e_cls[e_size] = best;
                e_size++;
                ptr[best]++;
                cnt[best]++;
            end
        end
        for (int c = 0; c < NCLS; c++) begin e_cnt[c] = cnt[c]; e_pop[c] = ptr[c]; end
    endtask

    // Inputs were set at a falling edge; results are registered at the next rising edge.
    task automatic step(string req);
        model();
        @(posedge clk);
        @(negedge clk);
        chk(req, "size", int'(iss_size), e_size);
        for (int k = 0; k < ISSUE_W; k++) begin
            chk(req, $sformatf("slot%0d seq", k), int'(iss_seq[k]), e_seq[k]);
            chk(req, $sformatf("slot%0d cls", k), int'(iss_cls[k]), e_cls[k]);
        end
        for (int c = 0; c < NCLS; c++) begin
            chk(req, $sformatf("cls%0d count", c), int'(cls_cnt[c]), e_cnt[c]);
            chk(req, $sformatf("cls%0d pop", c), int'(pop_cnt[c]), e_pop[c]);
        end
    endtask

    task automatic fill_rand();
        clear_all();
        for (int c = 0; c < NCLS; c++) begin
            int n;
            int s;
            n = int'($urandom_range(0, WIN));
            s = int'($urandom_range(0, 30));
            for (int i = 0; i < n; i++) begin
                s = s + 1 + int'($urandom_range(0, 20));
                put(c, i, (s << 3) | c, ($urandom_range(0, 3) == 0));
            end
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        clear_all();
        put(0, 0, 5, 1'b0);
        repeat (3) @(negedge clk);
        // R1: outputs stay zero while reset is held, even with heads present.
        chk("R1", "size in reset", int'(iss_size), 0);
        chk("R1", "slot0 seq in reset", int'(iss_seq[0]), 0);
        chk("R1", "int pop in reset", int'(pop_cnt[0]), 0);
        rst_n = 1'b1;

        // R3: four old integer entries, but only two may go; floating-point fills in.
        clear_all();
        for (int i = 0; i < 4; i++) put(0, i, 10 + i, 1'b0);
        put(1, 0, 50, 1'b0); put(1, 1, 60, 1'b0);
        step("R3");
        chk("R3", "int capped", int'(cls_cnt[0]), 2);
        chk("R3", "fp fills", int'(cls_cnt[1]), 2);

        // R5: only miscellaneous entries, all four slots taken.
        clear_all();
        for (int i = 0; i < 4; i++) put(4, i, 3 * i + 1, 1'b0);
        step("R5");
        chk("R5", "misc fills width", int'(cls_cnt[4]), 4);

        // R6: two squashed integer heads are discarded without slots.
        clear_all();
        put(0, 0, 1, 1'b1); put(0, 1, 2, 1'b1); put(0, 2, 30, 1'b0);
        put(2, 0, 20, 1'b0);
        step("R6");
        chk("R6", "int pop counts discards", int'(pop_cnt[0]), 3);
        chk("R6", "size excludes discards", int'(iss_size), 2);

        // R7: squashed branch behind a capped branch stays put.
        clear_all();
        put(2, 0, 10, 1'b0); put(2, 1, 18, 1'b1); put(2, 2, 26, 1'b0);
        put(0, 0, 40, 1'b0); put(0, 1, 48, 1'b0);
        step("R7");
        chk("R7", "branch pop after cap", int'(pop_cnt[2]), 1);

        // R7: squashed fp entry behind the last filled slot stays put.
        clear_all();
        put(4, 0, 1, 1'b0); put(4, 1, 3, 1'b0); put(4, 2, 5, 1'b0);
        put(1, 0, 7, 1'b0); put(1, 1, 9, 1'b1);
        step("R7");
        chk("R7", "fp pop after width", int'(pop_cnt[1]), 1);

        // R8: empty window issues nothing.
        clear_all();
        step("R8");
        chk("R8", "empty size", int'(iss_size), 0);

        // R10: identical inputs on consecutive cycles give the same counts.
        clear_all();
        put(0, 0, 4, 1'b0); put(0, 1, 6, 1'b0); put(3, 0, 5, 1'b0);
        step("R10");
        step("R10");
        chk("R10", "int count no carry", int'(cls_cnt[0]), 2);

        // R2 R4 R9: random windows against the reference.
        for (int n = 0; n < 400; n++) begin
            fill_rand();
            step("R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule